// File: doc/BRIEF.md
# Prioritized Instruction Address Sequencer

The block holds the live instruction address of a processor with four priority levels, plus one saved address slot per level. On every fetch strobe it sends the live address to a registered storage-address output and advances the live address by one. As a result, while an instruction executes, the live value already points at the following word. A branch or an operator-console write can replace the live value instead of the increment.

A level-change strobe carries the level being left and the level being entered. When the new level is more urgent (a lower number), the running address is parked in the slot of the level being left, and execution starts at a supplied entry address. When the new level is less urgent, the live address is reloaded from the slot of the level being resumed. Slot 0 never serves as a save slot, because level 0 cannot be interrupted. Instead, every fetch moves into slot 0 the address of the instruction that was executing until then. The console can read any slot or the live value through one combinational read port.

Top module: `prio_iaddr_seq`

## Requirements
- R1: After reset the live address, the storage-address output and all four slots read 0x0000.
- R2: With only the fetch strobe high, the storage-address output takes the current live address in the next cycle, and the live address becomes that value plus one.
- R3: The increment wraps: a fetch at live address 0xFFFF leaves the live address at 0x0000.
- R4: A branch strobe loads the branch target into the live address and takes precedence over the increment. A fetch in the same cycle still presents the pre-branch address on the storage-address output.
- R5: A console write loads the console data into the live address and takes precedence over both a branch and the increment.
- R6: A level switch whose new level number is lower than the old one stores the live address into the slot numbered by the old level and loads the entry address into the live address.
- R7: A level switch whose new level number is higher than the old one reloads the live address from the slot numbered by the new level and leaves every slot unchanged.
- R8: During a level switch with differing levels, fetch, branch and console write have no effect: the storage-address output and slot 0 hold, and the live address follows only R6 or R7.
- R9: A level switch whose old and new levels are equal changes neither the live address nor any slot.
- R10: Each fetch that is not overridden by a level switch copies the previous storage-address output into slot 0.
- R11: Console select values 0 to 3 read slot 0 to 3. Select value 4, and any higher value, reads the live address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_i | input | 1 | Fetch strobe |
| sar_o | output | 16 | Registered storage address of the word being fetched |
| branch_en_i | input | 1 | Branch load strobe |
| branch_addr_i | input | 16 | Branch target |
| entry_addr_i | input | 16 | Start address of a newly entered, more urgent level |
| sw_i | input | 1 | One-cycle level switch strobe |
| old_lvl_i | input | 2 | Level being left |
| new_lvl_i | input | 2 | Level being entered |
| con_wr_i | input | 1 | Console write strobe for the live address |
| con_wdata_i | input | 16 | Console write data |
| con_sel_i | input | 3 | Console read select (0..3 slot, 4..7 live) |
| con_rdata_o | output | 16 | Console read data |
| iaddr_o | output | 16 | Live instruction address |

## Verification
The hardest situation to reach is a return that restores a slot filled during a nested chain of interrupts. Such a return is only meaningful when several levels have each parked a different address. The stimulus therefore walks a descent from level 3 to 2, 1 and 0, with fetches and distinct entry addresses in between, and then climbs back one level at a time. It also sweeps every ordered pair of old and new levels with a distinct preloaded live address. Switch cycles with fetch, branch and console write all raised show that the competing loads are dropped.

// File: rtl/iaddr_pkg.sv
package iaddr_pkg;

   typedef enum logic [1:0] {
      LVL_HOLD   = 2'd0,
      LVL_ENTER  = 2'd1,
      LVL_RETURN = 2'd2
   } lvl_act_e;

   typedef enum logic [2:0] {
      SRC_KEEP    = 3'd0,
      SRC_INC     = 3'd1,
      SRC_BRANCH  = 3'd2,
      SRC_CONSOLE = 3'd3,
      SRC_ENTRY   = 3'd4,
      SRC_RESTORE = 3'd5
   } pc_src_e;

endpackage

// File: rtl/iaddr_ctrl.sv
module iaddr_ctrl
   import iaddr_pkg::*;
#(
   parameter int NUM_LEVELS = 4,
   parameter int LVL_W      = 2
) (
   input  logic             sw_i,
   input  logic [LVL_W-1:0] old_lvl_i,
   input  logic [LVL_W-1:0] new_lvl_i,
   input  logic             fetch_i,
   input  logic             branch_en_i,
   input  logic             con_wr_i,
   output lvl_act_e         act_o,
   output pc_src_e          src_o,
   output logic             fetch_eff_o,
   output logic             save_en_o
);

   logic lvls_ok;

   generate
      if (NUM_LEVELS == (1 << LVL_W)) begin : g_full_code
         assign lvls_ok = 1'b1;
      end else begin : g_partial_code
         assign lvls_ok = (int'(old_lvl_i) < NUM_LEVELS) && (int'(new_lvl_i) < NUM_LEVELS);
      end
   endgenerate

   always_comb begin
      act_o = LVL_HOLD;
      if (sw_i && lvls_ok) begin
         if (new_lvl_i < old_lvl_i) begin
            act_o = LVL_ENTER;
         end else if (new_lvl_i > old_lvl_i) begin
            act_o = LVL_RETURN;
         end
      end
   end

   assign fetch_eff_o = fetch_i && (act_o == LVL_HOLD);
   assign save_en_o   = (act_o == LVL_ENTER);

   always_comb begin
      unique case (act_o)
         LVL_ENTER:  src_o = SRC_ENTRY;
         LVL_RETURN: src_o = SRC_RESTORE;
         default: begin
            if (con_wr_i) begin
               src_o = SRC_CONSOLE;
            end else if (branch_en_i) begin
               src_o = SRC_BRANCH;
            end else if (fetch_i) begin
               src_o = SRC_INC;
            end else begin
               src_o = SRC_KEEP;
            end
         end
      endcase
   end

endmodule

// File: rtl/iaddr_bank.sv
module iaddr_bank #(
   parameter int ADDR_W     = 16,
   parameter int NUM_LEVELS = 4,
   parameter int LVL_W      = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 fetch_eff_i,
   input  logic [ADDR_W-1:0]                    prev_sar_i,
   input  logic                                 save_en_i,
   input  logic [LVL_W-1:0]                     save_lvl_i,
   input  logic [ADDR_W-1:0]                    save_data_i,
   output logic [NUM_LEVELS-1:0][ADDR_W-1:0]    slot_o
);

   logic [NUM_LEVELS-1:0][ADDR_W-1:0] slot_q;

   generate
      for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_slot
         if (k == 0) begin : g_history
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  slot_q[k] <= '0;
               end else if (fetch_eff_i) begin
                  slot_q[k] <= prev_sar_i;
               end
            end
         end else begin : g_backup
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  slot_q[k] <= '0;
               end else if (save_en_i && (save_lvl_i == LVL_W'(k))) begin
                  slot_q[k] <= save_data_i;
               end
            end
         end
      end
   endgenerate

   assign slot_o = slot_q;

   AST_SLOT0_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_eff_i |=> slot_q[0] == $past(prev_sar_i)); // R10

   AST_SAVE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (save_en_i && save_lvl_i != '0) |=> slot_q[$past(save_lvl_i)] == $past(save_data_i)); // R6

   AST_SLOT0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_eff_i |=> $stable(slot_q[0])); // R8

endmodule

// File: rtl/iaddr_rd_mux.sv
module iaddr_rd_mux #(
   parameter int ADDR_W     = 16,
   parameter int NUM_LEVELS = 4,
   parameter int SEL_W      = 3
) (
   input  logic [SEL_W-1:0]                     sel_i,
   input  logic [NUM_LEVELS-1:0][ADDR_W-1:0]    slot_i,
   input  logic [ADDR_W-1:0]                    live_i,
   output logic [ADDR_W-1:0]                    rdata_o
);

   always_comb begin
      rdata_o = live_i;
      for (int k = 0; k < NUM_LEVELS; k++) begin
         if (sel_i == SEL_W'(k)) begin
            rdata_o = slot_i[k];
         end
      end
   end

endmodule

// File: rtl/prio_iaddr_seq.sv
module prio_iaddr_seq
   import iaddr_pkg::*;
#(
   parameter int              ADDR_W     = 16,
   parameter int              NUM_LEVELS = 4,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
   localparam int             LVL_W      = $clog2(NUM_LEVELS),
   localparam int             SEL_W      = $clog2(NUM_LEVELS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_i,
   output logic [ADDR_W-1:0] sar_o,
   input  logic              branch_en_i,
   input  logic [ADDR_W-1:0] branch_addr_i,
   input  logic [ADDR_W-1:0] entry_addr_i,
   input  logic              sw_i,
   input  logic [LVL_W-1:0]  old_lvl_i,
   input  logic [LVL_W-1:0]  new_lvl_i,
   input  logic              con_wr_i,
   input  logic [ADDR_W-1:0] con_wdata_i,
   input  logic [SEL_W-1:0]  con_sel_i,
   output logic [ADDR_W-1:0] con_rdata_o,
   output logic [ADDR_W-1:0] iaddr_o
);

   generate
      if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_width
         $error("prio_iaddr_seq: ADDR_W out of range");
      end
      if (NUM_LEVELS < 2) begin : g_bad_levels
         $error("prio_iaddr_seq: at least two levels needed");
      end
   endgenerate

   lvl_act_e                           act;
   pc_src_e                            src;
   logic                               fetch_eff;
   logic                               save_en;
   logic [ADDR_W-1:0]                  pc_q;
   logic [ADDR_W-1:0]                  pc_d;
   logic [ADDR_W-1:0]                  sar_q;
   logic [ADDR_W-1:0]                  restore_val;
   logic [NUM_LEVELS-1:0][ADDR_W-1:0]  slots;

   iaddr_ctrl #(
      .NUM_LEVELS (NUM_LEVELS),
      .LVL_W      (LVL_W)
   ) u_ctrl (
      .sw_i        (sw_i),
      .old_lvl_i   (old_lvl_i),
      .new_lvl_i   (new_lvl_i),
      .fetch_i     (fetch_i),
      .branch_en_i (branch_en_i),
      .con_wr_i    (con_wr_i),
      .act_o       (act),
      .src_o       (src),
      .fetch_eff_o (fetch_eff),
      .save_en_o   (save_en)
   );

   iaddr_bank #(
      .ADDR_W     (ADDR_W),
      .NUM_LEVELS (NUM_LEVELS),
      .LVL_W      (LVL_W)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .fetch_eff_i (fetch_eff),
      .prev_sar_i  (sar_q),
      .save_en_i   (save_en),
      .save_lvl_i  (old_lvl_i),
      .save_data_i (pc_q),
      .slot_o      (slots)
   );

   iaddr_rd_mux #(
      .ADDR_W     (ADDR_W),
      .NUM_LEVELS (NUM_LEVELS),
      .SEL_W      (SEL_W)
   ) u_rd (
      .sel_i   (con_sel_i),
      .slot_i  (slots),
      .live_i  (pc_q),
      .rdata_o (con_rdata_o)
   );

   assign restore_val = slots[new_lvl_i];

   always_comb begin
      unique case (src)
         SRC_INC:     pc_d = pc_q + ADDR_W'(1);
         SRC_BRANCH:  pc_d = branch_addr_i;
         SRC_CONSOLE: pc_d = con_wdata_i;
         SRC_ENTRY:   pc_d = entry_addr_i;
         SRC_RESTORE: pc_d = restore_val;
         default:     pc_d = pc_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= RESET_ADDR;
         sar_q <= '0;
      end else begin
         pc_q <= pc_d;
         if (fetch_eff) begin
            sar_q <= pc_q;
         end
      end
   end

   assign sar_o   = sar_q;
   assign iaddr_o = pc_q;

   AST_FETCH_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_i && !sw_i && !branch_en_i && !con_wr_i)
         |=> (pc_q == $past(pc_q) + ADDR_W'(1)) && (sar_q == $past(pc_q))); // R2

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_i && !sw_i && !branch_en_i && !con_wr_i && (&pc_q)) |=> pc_q == '0); // R3

   AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (branch_en_i && !con_wr_i && act == LVL_HOLD) |=> pc_q == $past(branch_addr_i)); // R4

   AST_CONSOLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (con_wr_i && act == LVL_HOLD) |=> pc_q == $past(con_wdata_i)); // R5

   AST_ENTRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (act == LVL_ENTER) |=> pc_q == $past(entry_addr_i)); // R6

   AST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      (act == LVL_RETURN) |=> pc_q == $past(restore_val)); // R7

   AST_SWITCH_SAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (act != LVL_HOLD) |=> $stable(sar_q)); // R8

   AST_SAME_LVL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_i && old_lvl_i == new_lvl_i && !fetch_i && !branch_en_i && !con_wr_i)
         |=> $stable(pc_q) && $stable(slots)); // R9

endmodule

// File: tb/sim_prio_iaddr_seq.sv
`timescale 1ns/100ps
module sim_prio_iaddr_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_i = 1'b0;
   logic [15:0] sar_o;
   logic        branch_en_i = 1'b0;
   logic [15:0] branch_addr_i = '0;
   logic [15:0] entry_addr_i = '0;
   logic        sw_i = 1'b0;
   logic [1:0]  old_lvl_i = '0;
   logic [1:0]  new_lvl_i = '0;
   logic        con_wr_i = 1'b0;
   logic [15:0] con_wdata_i = '0;
   logic [2:0]  con_sel_i = '0;
   logic [15:0] con_rdata_o;
   logic [15:0] iaddr_o;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic [15:0] m_pc, m_sar;
   logic [15:0] m_bk [4];

   always #5 clk = ~clk;

   prio_iaddr_seq u0 (
      .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .sar_o(sar_o),
      .branch_en_i(branch_en_i), .branch_addr_i(branch_addr_i),
      .entry_addr_i(entry_addr_i), .sw_i(sw_i), .old_lvl_i(old_lvl_i),
      .new_lvl_i(new_lvl_i), .con_wr_i(con_wr_i), .con_wdata_i(con_wdata_i),
      .con_sel_i(con_sel_i), .con_rdata_o(con_rdata_o), .iaddr_o(iaddr_o)
   );

   task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "live", iaddr_o, m_pc);
      chk(tag, "sar", sar_o, m_sar);
      for (int s = 0; s < 8; s++) begin
         con_sel_i = 3'(s);
         #0.3;
         if (s < 4) chk(tag, $sformatf("slot%0d", s), con_rdata_o, m_bk[s]);
         else       chk("R11", $sformatf("sel%0d", s), con_rdata_o, m_pc);
      end
   endtask

   task automatic step(input string tag, input logic f, input logic br, input logic [15:0] ba,
                       input logic cw, input logic [15:0] cd, input logic s,
                       input logic [1:0] o, input logic [1:0] n, input logic [15:0] ea);
      logic [15:0] opc, osar;
      @(negedge clk);
      fetch_i = f; branch_en_i = br; branch_addr_i = ba; con_wr_i = cw; con_wdata_i = cd;
      sw_i = s; old_lvl_i = o; new_lvl_i = n; entry_addr_i = ea;
      opc = m_pc; osar = m_sar;
      if (s && n < o) begin
         m_bk[o] = opc; m_pc = ea;
      end else if (s && n > o) begin
         m_pc = m_bk[n];
      end else begin
         if (f) begin m_bk[0] = osar; m_sar = opc; end
         if (cw)      m_pc = cd;
         else if (br) m_pc = ba;
         else if (f)  m_pc = opc + 16'd1;
      end
      @(posedge clk);
      #1;
      fetch_i = 1'b0; branch_en_i = 1'b0; con_wr_i = 1'b0; sw_i = 1'b0;
      compare(tag);
   endtask

   task automatic fetch(input string tag);
      step(tag, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, 2'd0, 2'd0, '0);
   endtask

   task automatic cload(input logic [15:0] v);
      step("R5", 1'b0, 1'b0, '0, 1'b1, v, 1'b0, 2'd0, 2'd0, '0);
   endtask

   task automatic lswitch(input string tag, input logic [1:0] o, input logic [1:0] n, input logic [15:0] ea);
      step(tag, 1'b0, 1'b0, '0, 1'b0, '0, 1'b1, o, n, ea);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [15:0] lf;
      m_pc = '0; m_sar = '0;
      for (int k = 0; k < 4; k++) m_bk[k] = '0;
      repeat (3) @(posedge clk);
      #1;
      compare("R1");
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      compare("R1");

      for (int i = 0; i < 12; i++) fetch("R2");
      for (int i = 0; i < 4; i++)  fetch("R10");

      cload(16'hFFFE);
      for (int i = 0; i < 3; i++) fetch("R3");

      step("R4", 1'b0, 1'b1, 16'h4242, 1'b0, '0, 1'b0, 2'd0, 2'd0, '0);
      step("R4", 1'b1, 1'b1, 16'h0777, 1'b0, '0, 1'b0, 2'd0, 2'd0, '0);
      fetch("R4");
      step("R5", 1'b1, 1'b1, 16'h1111, 1'b1, 16'h2222, 1'b0, 2'd0, 2'd0, '0);
      step("R5", 1'b0, 1'b1, 16'h3333, 1'b1, 16'h5555, 1'b0, 2'd0, 2'd0, '0);

      // nested descent and climb back
      cload(16'hA300);
      fetch("R6");
      lswitch("R6", 2'd3, 2'd2, 16'h0200);
      fetch("R6"); fetch("R6");
      lswitch("R6", 2'd2, 2'd1, 16'h0100);
      fetch("R6");
      lswitch("R6", 2'd1, 2'd0, 16'h0010);
      fetch("R10");
      lswitch("R7", 2'd0, 2'd1, '0);
      fetch("R7");
      lswitch("R7", 2'd1, 2'd2, '0);
      lswitch("R7", 2'd2, 2'd3, '0);

      // every ordered pair of levels
      for (int o = 0; o < 4; o++) begin
         for (int n = 0; n < 4; n++) begin
            cload(16'h1000 + 16'(o * 16 + n));
            lswitch((n < o) ? "R6" : (n > o) ? "R7" : "R9", 2'(o), 2'(n), 16'h8000 + 16'(o * 4 + n));
            fetch("R2");
         end
      end

      // competing loads during a switch are dropped
      cload(16'hBEEF);
      step("R8", 1'b1, 1'b1, 16'h1234, 1'b1, 16'h5678, 1'b1, 2'd3, 2'd1, 16'h0C00);
      step("R8", 1'b1, 1'b1, 16'h4321, 1'b1, 16'h8765, 1'b1, 2'd1, 2'd3, '0);
      step("R9", 1'b1, 1'b0, '0, 1'b0, '0, 1'b1, 2'd2, 2'd2, 16'h9999);

      // mixed pseudo-random traffic
      lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step("R2", lf[0], lf[1] & lf[2], {lf[7:0], lf[15:8]}, lf[3] & lf[4] & lf[5],
              lf ^ 16'h5A5A, lf[6] & lf[7], lf[9:8], lf[11:10], ~lf);
      end

      done = 1'b1;
      finish_run();
   end

endmodule